// File: doc/BRIEF.md
# Request/Response Bus Splitter-Arbiter

This block is the interconnect for a small 8-bit request/response bus on which every link between a master and a slave is point-to-point and nothing is tri-stated. Several masters share one path to the slaves. An arbiter picks one request at a time, using either fixed priority or round robin. It issues that request as a single-cycle command and remembers which master owns it. It then hands the response back to that master alone.

On the slave side, a splitter compares the upper address bits of the command with a set of equal-sized regions, one region per slave. Only the read and write strobes are separate per slave. The address and the write data go to every slave unchanged. The responses of all slaves are combined with a plain OR, so a slave has to hold its acknowledge and data at zero whenever it is not answering. An address that lands outside every region is answered by a built-in default responder with zero data, so such an access cannot stall the bus.

A master raises a read or a write request together with its address and write data. It holds the request until its acknowledge arrives, and it drops the request in the cycle the acknowledge is seen.

Top module: `rrf_fabric`

## Requirements
- R1: While reset is held and in the first cycle after it, every master acknowledge and every slave strobe is low and every master read-data lane is zero.
- R2: A command whose region index (address bits ADDR_W-1 down to REGION_BITS) is k, with k < NUM_SLV, pulses the read or write strobe of slave k alone for one cycle. At most one slave strobe is high in any cycle.
- R3: The address and write data seen by the slaves are the granted master's address and write data, unchanged.
- R4: The response returned to the master is the OR of all slave responses, so a read of a mapped address returns the byte last written there through the fabric.
- R5: A request whose region index is NUM_SLV or above reaches no slave. On an idle fabric it is acknowledged with zero read data on the third rising edge after the request is presented. A write of this kind changes no stored data.
- R6: Only one access is in flight at a time. A command pulse is never followed by another command in the next cycle, and no slave acknowledge is accepted while the arbiter is idle.
- R7: The acknowledge and read data go only to the master that was granted. At most one master acknowledge is high at a time, and every read-data lane is zero in cycles with no acknowledge.
- R8: With ROUND_ROBIN = 0, the lowest-numbered requesting master wins.
- R9: With ROUND_ROBIN = 1, the search for a winner starts at the master after the one last granted. After reset the search starts at master 0.
- R10: No new command is issued in the cycle that follows an acknowledge to a master.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| m_rd | input | NUM_MST | Read request per master, held until acknowledged |
| m_wr | input | NUM_MST | Write request per master, held until acknowledged |
| m_addr | input | NUM_MST*ADDR_W | Address per master, master m in lane m |
| m_wdata | input | NUM_MST*DATA_W | Write data per master |
| m_ack | output | NUM_MST | One-cycle acknowledge per master |
| m_rdata | output | NUM_MST*DATA_W | Read data per master, valid with its acknowledge, zero otherwise |
| s_rd | output | NUM_SLV | One-cycle read strobe per slave |
| s_wr | output | NUM_SLV | One-cycle write strobe per slave |
| s_addr | output | ADDR_W | Address shared by all slaves |
| s_wdata | output | DATA_W | Write data shared by all slaves |
| s_ack | input | NUM_SLV | Acknowledge per slave, zero when not answering |
| s_rdata | input | NUM_SLV*DATA_W | Read data per slave, zero when not answering |

## Verification
The assertions assume a well-behaved bus edge. Each slave answers every strobe exactly once and holds zeros on its response otherwise. Each master raises at most one of read or write and keeps its request stable until its acknowledge. The bench's slave models answer each strobe once, after a random delay of zero to two cycles, and clear their outputs at every other time. Its masters draw random reads and writes, about one in eight of them unmapped, on address lanes that no other master touches, and release each request at the acknowledge. Because no two masters share an address, completion order never affects the expected read data.

// File: rtl/rrf_pkg.sv
package rrf_pkg;

  typedef enum logic {
    ARB_IDLE = 1'b0,
    ARB_BUSY = 1'b1
  } arb_state_e;

endpackage

// File: rtl/rrf_picker.sv
module rrf_picker #(
  parameter int N           = 3,
  parameter bit ROUND_ROBIN = 1'b1,
  localparam int IW         = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  input  logic [IW-1:0] last_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);

  generate
    if (ROUND_ROBIN) begin : g_rr
      // search begins one past the previous winner
      always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int k = 0; k < N; k++) begin
          int c;
          c = (int'(last_i) + 1 + k) % N;
          if (!found_o && req_i[c]) begin
            found_o = 1'b1;
            idx_o   = IW'(c);
          end
        end
      end
    end else begin : g_fixed
      // lowest index wins
      always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int k = 0; k < N; k++) begin
          if (!found_o && req_i[k]) begin
            found_o = 1'b1;
            idx_o   = IW'(k);
          end
        end
      end
    end
  endgenerate

endmodule

// File: rtl/rrf_arbiter.sv
module rrf_arbiter
  import rrf_pkg::*;
#(
  parameter int NUM_MST     = 3,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter bit ROUND_ROBIN = 1'b1,
  localparam int IW         = (NUM_MST > 1) ? $clog2(NUM_MST) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_MST-1:0]          m_rd_i,
  input  logic [NUM_MST-1:0]          m_wr_i,
  input  logic [NUM_MST*ADDR_W-1:0]   m_addr_i,
  input  logic [NUM_MST*DATA_W-1:0]   m_wdata_i,
  output logic [NUM_MST-1:0]          m_ack_o,
  output logic [NUM_MST*DATA_W-1:0]   m_rdata_o,
  output logic                        bus_rd_o,
  output logic                        bus_wr_o,
  output logic [ADDR_W-1:0]           bus_addr_o,
  output logic [DATA_W-1:0]           bus_wdata_o,
  input  logic                        bus_ack_i,
  input  logic [DATA_W-1:0]           bus_rdata_i
);

  arb_state_e                state_q;
  logic [IW-1:0]             owner_q;
  logic [IW-1:0]             last_q;
  logic [NUM_MST-1:0]        ack_q;
  logic [NUM_MST*DATA_W-1:0] rdata_q;
  logic                      cmd_rd_q, cmd_wr_q;
  logic [ADDR_W-1:0]         cmd_addr_q;
  logic [DATA_W-1:0]         cmd_wdata_q;

  logic [NUM_MST-1:0]        pending;
  logic                      pick_ok;
  logic [IW-1:0]             pick_idx;
  logic                      take;

  assign pending = m_rd_i | m_wr_i;

  rrf_picker #(
    .N           (NUM_MST),
    .ROUND_ROBIN (ROUND_ROBIN)
  ) u_picker (
    .req_i   (pending),
    .last_i  (last_q),
    .found_o (pick_ok),
    .idx_o   (pick_idx)
  );

  // a pending acknowledge blocks any new grant for that cycle
  assign take = (state_q == ARB_IDLE) && !(|ack_q) && pick_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ARB_IDLE;
      owner_q     <= '0;
      last_q      <= IW'(NUM_MST - 1);
      ack_q       <= '0;
      rdata_q     <= '0;
      cmd_rd_q    <= 1'b0;
      cmd_wr_q    <= 1'b0;
      cmd_addr_q  <= '0;
      cmd_wdata_q <= '0;
    end else begin
      cmd_rd_q <= 1'b0;
      cmd_wr_q <= 1'b0;
      ack_q    <= '0;
      rdata_q  <= '0;
      case (state_q)
        ARB_IDLE: begin
          if (take) begin
            owner_q     <= pick_idx;
            last_q      <= pick_idx;
            cmd_rd_q    <= m_rd_i[pick_idx];
            cmd_wr_q    <= m_wr_i[pick_idx] & ~m_rd_i[pick_idx];
            cmd_addr_q  <= m_addr_i[pick_idx*ADDR_W +: ADDR_W];
            cmd_wdata_q <= m_wdata_i[pick_idx*DATA_W +: DATA_W];
            state_q     <= ARB_BUSY;
          end
        end
        default: begin
          if (bus_ack_i) begin
            ack_q[owner_q]                   <= 1'b1;
            rdata_q[owner_q*DATA_W +: DATA_W] <= bus_rdata_i;
            state_q                          <= ARB_IDLE;
          end
        end
      endcase
    end
  end

  assign m_ack_o     = ack_q;
  assign m_rdata_o   = rdata_q;
  assign bus_rd_o    = cmd_rd_q;
  assign bus_wr_o    = cmd_wr_q;
  assign bus_addr_o  = cmd_addr_q;
  assign bus_wdata_o = cmd_wdata_q;

  AST_SINGLE_CMD: assert property (@(posedge clk) disable iff (rst)
    (cmd_rd_q | cmd_wr_q) |=> !(cmd_rd_q | cmd_wr_q)); // R6

  AST_ACK_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
    bus_ack_i |-> (state_q == ARB_BUSY)); // R6

  AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ack_q)); // R7

  AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (rst)
    !(|ack_q) |-> (rdata_q == '0)); // R7

  AST_NO_GRANT_ON_ACK: assert property (@(posedge clk) disable iff (rst)
    (|ack_q) |=> !(cmd_rd_q | cmd_wr_q)); // R10

endmodule

// File: rtl/rrf_splitter.sv
module rrf_splitter #(
  parameter int NUM_SLV     = 4,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int REGION_BITS = 5,
  localparam int RW         = ADDR_W - REGION_BITS
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_rd_i,
  input  logic                       bus_wr_i,
  input  logic [ADDR_W-1:0]          bus_addr_i,
  input  logic [DATA_W-1:0]          bus_wdata_i,
  output logic                       bus_ack_o,
  output logic [DATA_W-1:0]          bus_rdata_o,
  output logic [NUM_SLV-1:0]         s_rd_o,
  output logic [NUM_SLV-1:0]         s_wr_o,
  output logic [ADDR_W-1:0]          s_addr_o,
  output logic [DATA_W-1:0]          s_wdata_o,
  input  logic [NUM_SLV-1:0]         s_ack_i,
  input  logic [NUM_SLV*DATA_W-1:0]  s_rdata_i
);

  logic [RW-1:0]      region;
  logic [NUM_SLV-1:0] hit;
  logic               miss;
  logic               dflt_ack_q;

  assign region = bus_addr_i[ADDR_W-1:REGION_BITS];

  genvar gi;
  generate
    for (gi = 0; gi < NUM_SLV; gi++) begin : g_port
      assign hit[gi]    = (region == RW'(gi));
      assign s_rd_o[gi] = bus_rd_i & hit[gi];
      assign s_wr_o[gi] = bus_wr_i & hit[gi];
    end
  endgenerate

  assign s_addr_o  = bus_addr_i;
  assign s_wdata_o = bus_wdata_i;
  assign miss      = (bus_rd_i | bus_wr_i) & ~(|hit);

  // default responder for addresses no slave claims
  always_ff @(posedge clk) begin
    if (rst) dflt_ack_q <= 1'b0;
    else     dflt_ack_q <= miss;
  end

  // response merge: idle ports contribute zeros
  always_comb begin
    bus_ack_o   = dflt_ack_q;
    bus_rdata_o = '0;
    for (int i = 0; i < NUM_SLV; i++) begin
      bus_ack_o   = bus_ack_o | s_ack_i[i];
      bus_rdata_o = bus_rdata_o | s_rdata_i[i*DATA_W +: DATA_W];
    end
  end

  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(s_rd_o | s_wr_o)); // R2

  AST_DFLT_AFTER_CMD: assert property (@(posedge clk) disable iff (rst)
    dflt_ack_q |-> $past(bus_rd_i | bus_wr_i)); // R5

endmodule

// File: rtl/rrf_fabric.sv
module rrf_fabric #(
  parameter int NUM_MST     = 3,
  parameter int NUM_SLV     = 4,
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int REGION_BITS = 5,
  parameter bit ROUND_ROBIN = 1'b1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_MST-1:0]          m_rd,
  input  logic [NUM_MST-1:0]          m_wr,
  input  logic [NUM_MST*ADDR_W-1:0]   m_addr,
  input  logic [NUM_MST*DATA_W-1:0]   m_wdata,
  output logic [NUM_MST-1:0]          m_ack,
  output logic [NUM_MST*DATA_W-1:0]   m_rdata,
  output logic [NUM_SLV-1:0]          s_rd,
  output logic [NUM_SLV-1:0]          s_wr,
  output logic [ADDR_W-1:0]           s_addr,
  output logic [DATA_W-1:0]           s_wdata,
  input  logic [NUM_SLV-1:0]          s_ack,
  input  logic [NUM_SLV*DATA_W-1:0]   s_rdata
);

  logic              bus_rd, bus_wr, bus_ack;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata, bus_rdata;

  rrf_arbiter #(
    .NUM_MST     (NUM_MST),
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .ROUND_ROBIN (ROUND_ROBIN)
  ) u_arbiter (
    .clk         (clk),
    .rst         (rst),
    .m_rd_i      (m_rd),
    .m_wr_i      (m_wr),
    .m_addr_i    (m_addr),
    .m_wdata_i   (m_wdata),
    .m_ack_o     (m_ack),
    .m_rdata_o   (m_rdata),
    .bus_rd_o    (bus_rd),
    .bus_wr_o    (bus_wr),
    .bus_addr_o  (bus_addr),
    .bus_wdata_o (bus_wdata),
    .bus_ack_i   (bus_ack),
    .bus_rdata_i (bus_rdata)
  );

  rrf_splitter #(
    .NUM_SLV     (NUM_SLV),
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .REGION_BITS (REGION_BITS)
  ) u_splitter (
    .clk         (clk),
    .rst         (rst),
    .bus_rd_i    (bus_rd),
    .bus_wr_i    (bus_wr),
    .bus_addr_i  (bus_addr),
    .bus_wdata_i (bus_wdata),
    .bus_ack_o   (bus_ack),
    .bus_rdata_o (bus_rdata),
    .s_rd_o      (s_rd),
    .s_wr_o      (s_wr),
    .s_addr_o    (s_addr),
    .s_wdata_o   (s_wdata),
    .s_ack_i     (s_ack),
    .s_rdata_i   (s_rdata)
  );

endmodule

// File: tb/rrf_fabric_tb.sv
module rrf_fabric_tb;

  localparam int NM = 3;
  localparam int NS = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  // instance A: round robin, with slave models
  logic [NM-1:0]    a_rd = '0, a_wr = '0, a_ack;
  logic [NM*8-1:0]  a_addr = '0, a_wdata = '0, a_rdata;
  logic [NS-1:0]    sa_rd, sa_wr, sa_ack;
  logic [7:0]       sa_addr, sa_wdata;
  logic [NS*8-1:0]  sa_rdata;

  // instance B: fixed priority, no slaves attached
  logic [NM-1:0]    b_rd = '0, b_wr = '0, b_ack;
  logic [NM*8-1:0]  b_addr = '0, b_wdata = '0, b_rdata;
  logic [NS-1:0]    sb_rd, sb_wr;
  logic [7:0]       sb_addr, sb_wdata;

  rrf_fabric #(.ROUND_ROBIN(1'b1)) u_dut (
    .clk(clk), .rst(rst), .m_rd(a_rd), .m_wr(a_wr), .m_addr(a_addr),
    .m_wdata(a_wdata), .m_ack(a_ack), .m_rdata(a_rdata), .s_rd(sa_rd),
    .s_wr(sa_wr), .s_addr(sa_addr), .s_wdata(sa_wdata), .s_ack(sa_ack),
    .s_rdata(sa_rdata));

  rrf_fabric #(.ROUND_ROBIN(1'b0)) u_dut_fp (
    .clk(clk), .rst(rst), .m_rd(b_rd), .m_wr(b_wr), .m_addr(b_addr),
    .m_wdata(b_wdata), .m_ack(b_ack), .m_rdata(b_rdata), .s_rd(sb_rd),
    .s_wr(sb_wr), .s_addr(sb_addr), .s_wdata(sb_wdata), .s_ack('0),
    .s_rdata('0));

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;
  logic [7:0] ref_mem [256];
  logic [7:0] smem [NS][32];

  function automatic bit is_mapped(input logic [7:0] a);
    return (int'(a[7:5]) < NS);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // slave models for instance A plus bus-side port checks
  int   pend [NS];
  bit   prd  [NS];
  logic [4:0] pofs [NS];
  bit   prev_ack = 0;
  initial begin
    sa_ack = '0; sa_rdata = '0;
    for (int i = 0; i < NS; i++) begin
      pend[i] = 0;
      for (int j = 0; j < 32; j++) smem[i][j] = 8'h00;
    end
    forever begin
      @(negedge clk);
      sa_ack = '0; sa_rdata = '0;
      if (!rst) begin
        if (prev_ack) check(!(|(sa_rd | sa_wr)), "R10 strobe after ack", int'(sa_rd | sa_wr), 0);
        if (|(sa_rd | sa_wr)) check($countones(sa_rd | sa_wr) == 1, "R2 one strobe", int'(sa_rd | sa_wr), 1);
        for (int i = 0; i < NS; i++) begin
          if (pend[i] > 0) begin
            pend[i]--;
            if (pend[i] == 0) begin
              sa_ack[i] = 1'b1;
              sa_rdata[i*8 +: 8] = prd[i] ? smem[i][pofs[i]] : 8'h00;
            end
          end
          if (sa_rd[i] | sa_wr[i]) begin
            bit found;
            found = 0;
            check(int'(sa_addr[7:5]) == i, "R2 region decode", int'(sa_addr[7:5]), i);
            for (int m = 0; m < NM; m++)
              if ((a_rd[m] | a_wr[m]) && a_addr[m*8 +: 8] == sa_addr &&
                  (!sa_wr[i] || a_wdata[m*8 +: 8] == sa_wdata)) found = 1;
            check(found, "R3 broadcast addr/data", int'(sa_addr), int'(sa_addr));
            if (sa_wr[i]) smem[i][sa_addr[4:0]] = sa_wdata;
            prd[i]  = sa_rd[i];
            pofs[i] = sa_addr[4:0];
            pend[i] = int'($urandom % 3);
            if (pend[i] == 0) begin
              sa_ack[i] = 1'b1;
              sa_rdata[i*8 +: 8] = prd[i] ? smem[i][pofs[i]] : 8'h00;
            end
          end
        end
        for (int m = 0; m < NM; m++)
          if (!a_ack[m] && a_rdata[m*8 +: 8] != 8'h00)
            check(0, "R7 idle lane zero", int'(a_rdata[m*8 +: 8]), 0);
        if ($countones(a_ack) > 1) check(0, "R7 single ack", int'(a_ack), 1);
        prev_ack = |a_ack;
      end
    end
  end

  // one transaction on instance A, returns data and cycles to ack
  task automatic a_txn(input int m, input bit wr, input logic [7:0] addr,
                       input logic [7:0] wd, output logic [7:0] rd, output int cyc);
    @(negedge clk);
    a_addr[m*8 +: 8]  = addr;
    a_wdata[m*8 +: 8] = wd;
    a_rd[m] = ~wr;
    a_wr[m] = wr;
    cyc = 0;
    rd  = 8'h00;
    do begin
      @(negedge clk);
      cyc++;
    end while (!a_ack[m] && cyc < 60);
    rd = a_rdata[m*8 +: 8];
    a_rd[m] = 1'b0;
    a_wr[m] = 1'b0;
    check(cyc < 60, "R6 ack arrives", cyc, 0);
  endtask

  task automatic master_proc(input int m);
    for (int t = 0; t < 60; t++) begin
      logic [7:0] addr, wd, rd;
      bit wr;
      int cyc;
      int gap;
      gap = int'($urandom % 4);
      repeat (gap) @(negedge clk);
      addr = 8'($urandom);
      addr[7] = ($urandom % 8 == 0);
      addr[1:0] = 2'(m);
      wr = $urandom % 2;
      wd = 8'($urandom);
      a_txn(m, wr, addr, wd, rd, cyc);
      if (wr) begin
        if (is_mapped(addr)) ref_mem[addr] = wd;
      end else if (is_mapped(addr)) begin
        check(rd == ref_mem[addr], "R4 read data", int'(rd), int'(ref_mem[addr]));
      end else begin
        check(rd == 8'h00, "R5 unmapped zero", int'(rd), 0);
      end
    end
  endtask

  initial begin
    int oa [3];
    int ob [3];
    int na, nb;
    bit raised;
    logic [7:0] rd;
    int cyc;
    void'($urandom(32'd4711));
    for (int k = 0; k < 256; k++) ref_mem[k] = 8'h00;
    repeat (4) @(negedge clk);
    check(a_ack == '0 && a_rdata == '0 && (sa_rd | sa_wr) == '0, "R1 in reset", int'(a_ack), 0);
    rst = 1'b0;
    @(negedge clk);
    check(a_ack == '0 && b_ack == '0 && a_rdata == '0, "R1 after reset", int'(a_ack), 0);
    check((sa_rd | sa_wr | sb_rd | sb_wr) == '0, "R1 strobes low", int'(sa_rd | sa_wr), 0);

    // arbitration race: masters 1 and 2 together, master 0 joins at first ack
    a_rd[1] = 1; a_addr[15:8] = 8'h90; a_rd[2] = 1; a_addr[23:16] = 8'hA0;
    b_rd[1] = 1; b_addr[15:8] = 8'h90; b_rd[2] = 1; b_addr[23:16] = 8'hA0;
    na = 0; nb = 0; raised = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      for (int m = 0; m < NM; m++) begin
        if (a_rd[m] && a_ack[m] && na < 3) begin a_rd[m] = 0; oa[na] = m; na++; end
        if (b_rd[m] && b_ack[m] && nb < 3) begin b_rd[m] = 0; ob[nb] = m; nb++; end
      end
      if (!raised && na > 0) begin
        raised = 1;
        a_rd[0] = 1; a_addr[7:0] = 8'hB0;
        b_rd[0] = 1; b_addr[7:0] = 8'hB0;
      end
    end
    a_rd = '0; b_rd = '0;
    check(na == 3 && oa[0] == 1 && oa[1] == 2 && oa[2] == 0, "R9 round robin order",
          oa[0]*100 + oa[1]*10 + oa[2], 120);
    check(nb == 3 && ob[0] == 1 && ob[1] == 0 && ob[2] == 2, "R8 fixed priority order",
          ob[0]*100 + ob[1]*10 + ob[2], 102);

    // unmapped access latency and no side effect
    a_txn(0, 1'b0, 8'hC4, 8'h00, rd, cyc);
    check(cyc == 3, "R5 unmapped latency", cyc, 3);
    check(rd == 8'h00, "R5 unmapped data", int'(rd), 0);
    a_txn(0, 1'b1, 8'h08, 8'h3C, rd, cyc);
    ref_mem[8'h08] = 8'h3C;
    a_txn(0, 1'b1, 8'h88, 8'hAA, rd, cyc);
    a_txn(0, 1'b0, 8'h08, 8'h00, rd, cyc);
    check(rd == 8'h3C, "R5 unmapped write ignored", int'(rd), 8'h3C);
    a_txn(1, 1'b1, 8'h65, 8'h5A, rd, cyc);
    ref_mem[8'h65] = 8'h5A;
    a_txn(1, 1'b0, 8'h65, 8'h00, rd, cyc);
    check(rd == 8'h5A, "R4 last region read", int'(rd), 8'h5A);

    fork
      master_proc(0);
      master_proc(1);
      master_proc(2);
    join

    repeat (5) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

endmodule